// File: doc/BRIEF.md
# NRZI Transmit Serializer

This block sits between an HDLC framer and the keying input of a half-duplex 1200 baud AFSK modem. The framer offers 16-bit words over a valid/ready handshake. The block sends each word out least significant bit first, one channel bit per bit-clock tick, with NRZI coding: a data 1 keeps the line level and a data 0 inverts it. The bit-rate timebase comes from outside as a single-cycle `bit_tick` strobe.

Words are loaded into a shift register one bit wider than a word. A marker bit sits above the data, so the register shows when only the marker is left and a new word is due. No bit counter is needed for this. On every tick the line register first takes the level that was computed on the tick before, and only then is the next level worked out. The value on the line therefore never depends on the word fetch that happens in the same cycle.

Push-to-talk (`ptt`) gates everything. While it is low the block holds its state, ignores ticks, drops `tx_en` and drives the line to its idle level. When `ptt` rises again the burst resumes with the stored NRZI level and the word bits that were not yet sent. Back-pressure works like this: `word_ready` is high only in a cycle that is both a tick and a reload point. The framer must hold `word_valid` and `word_data` steady until that cycle. A word transfers when `word_ready` and `word_valid` are both high. If `word_valid` is low at a reload point, the block sends a fill word in its place.

Top module: `nrzi_tx_serializer`

## Requirements
- R1: The line register changes only on a cycle where `bit_tick` and `ptt` are both high. On that cycle it takes the level computed on the previous such tick, so the level driven on tick n+1 is the one computed on tick n.
- R2: NRZI coding: with L(n) the level driven on tick n and d(n) the data bit consumed on tick n, L(n+1) = NOT(L(n) XOR d(n)). A 1 holds the level and a 0 toggles it.
- R3: Each word is sent LSB first (bit 0 on the first tick, bit WORD_W-1 last). Consecutive words follow with no gap ticks.
- R4: `word_ready` is high only in a cycle with `bit_tick` and `ptt` both high while the register holds nothing but the marker, or is empty. That is exactly one tick in every WORD_W ticks, and never in two consecutive cycles. A word is taken when `word_ready` and `word_valid` are both high.
- R5: If `word_valid` is low at a reload point, the fill word FILL_WORD (default 0x7E7E) is sent in its place, LSB first.
- R6: While `ptt` is low, `tx_en` is 0, `line_bit` is IDLE_LEVEL (default 1), `word_ready` is 0, and ticks have no effect. When `ptt` rises again, the burst continues from the stored level and the remaining bits.
- R7: A synchronous active-high `rst` clears the shift register and both line-level registers. The first tick afterwards loads a word, and the first level driven is 0. While `ptt` is high, `tx_en` is 1 and `line_bit` shows the line register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per channel bit |
| ptt | input | 1 | Push-to-talk; enables transmission |
| word_data | input | WORD_W | Word from the framer |
| word_valid | input | 1 | word_data holds a word |
| word_ready | output | 1 | Word accepted this cycle if valid |
| line_bit | output | 1 | NRZI line level to the modulator |
| tx_en | output | 1 | Transmitter keyed |

## Verification
The bench builds the block with WORD_W = 4, FILL_WORD = 4'h9 and IDLE_LEVEL = 1. With a word this narrow, every ordered pair of word values can be sent back to back: 256 pairs, starting from whatever line level the earlier traffic left behind. That covers every hold/toggle run across a word boundary. The same configuration makes fill-word substitution, a push-to-talk pause in the middle of a word and a reset during a stream cheap to hit, and every line level is checked against an NRZI model of the word queue.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  // Where the shift register takes its next value from on a tick
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,   // bits still pending, keep shifting
    SRC_WORD = 2'd1,   // marker reached, take the offered word
    SRC_FILL = 2'd2    // marker reached, nothing offered: fill word
  } reload_src_e;

  // Next NRZI line level: a 1 holds the level, a 0 inverts it
  function automatic logic nrzi_next(input logic cur_level, input logic data_bit);
    return ~(cur_level ^ data_bit);
  endfunction

endpackage

// File: rtl/nrzi_shift_store.sv
module nrzi_shift_store
  import nrzi_tx_pkg::*;
#(
  parameter int          WORD_W    = 16,
  parameter logic [WORD_W-1:0] FILL_WORD = 16'h7E7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              data_bit
);

  localparam int SR_W = WORD_W + 1;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_eff;
  logic            reload_due;
  reload_src_e     src;

  // Only the marker (or nothing) left: a fresh word is due
  assign reload_due = (sr_q[SR_W-1:1] == '0);
  assign word_ready = step & reload_due;

  always_comb begin
    if (!reload_due)     src = SRC_HOLD;
    else if (word_valid) src = SRC_WORD;
    else                 src = SRC_FILL;
  end

  always_comb begin
    case (src)
      SRC_WORD: sr_eff = {1'b1, word_data};
      SRC_FILL: sr_eff = {1'b1, FILL_WORD};
      default:  sr_eff = sr_q;
    endcase
  end

  assign data_bit = sr_eff[0];

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (step) sr_q <= sr_eff >> 1;
  end

endmodule

// File: rtl/nrzi_line_coder.sv
module nrzi_line_coder
  import nrzi_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic data_bit,
  output logic line_q,
  output logic tx_bit
);

  // line_q takes the level computed on the previous tick before the
  // new level is formed, so the line never waits on the word fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      tx_bit <= 1'b0;
    end else if (step) begin
      line_q <= tx_bit;
      tx_bit <= nrzi_next(tx_bit, data_bit);
    end
  end

endmodule

// File: rtl/nrzi_tx_serializer.sv
module nrzi_tx_serializer #(
  parameter int                WORD_W     = 16,
  parameter logic [WORD_W-1:0] FILL_WORD  = 16'h7E7E,
  parameter logic              IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              ptt,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              line_bit,
  output logic              tx_en
);

  logic step;
  logic data_bit;
  logic line_q;
  logic tx_bit;

  assign step = bit_tick & ptt;

  nrzi_shift_store #(
    .WORD_W    (WORD_W),
    .FILL_WORD (FILL_WORD)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .data_bit   (data_bit)
  );

  nrzi_line_coder u_coder (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .data_bit (data_bit),
    .line_q   (line_q),
    .tx_bit   (tx_bit)
  );

  assign tx_en    = ptt;
  assign line_bit = ptt ? line_q : IDLE_LEVEL;

endmodule

// File: rtl/nrzi_tx_checker.sv
module nrzi_tx_checker #(
  parameter logic FILL_LSB   = 1'b0,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic ptt,
  input logic word_lsb,
  input logic word_valid,
  input logic word_ready,
  input logic line_bit,
  input logic tx_en,
  input logic line_q,
  input logic tx_bit
);

  // R1: on a tick the line register takes the previously computed level
  assert_line_takes_prev_R1: assert property (@(posedge clk) disable iff (rst)
    (ptt && bit_tick) |=> (line_q == $past(tx_bit)));

  // R2: NRZI step applied to the accepted word's first bit
  assert_nrzi_word_R2: assert property (@(posedge clk) disable iff (rst)
    (word_ready && word_valid) |=> (tx_bit == ~($past(tx_bit) ^ $past(word_lsb))));

  // R4: ready only on an enabled tick
  assert_ready_gated_R4: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> (ptt && bit_tick));

  // R4: a reload is never due twice in a row
  assert_ready_single_R4: assert property (@(posedge clk) disable iff (rst)
    word_ready |=> !word_ready);

  // R5: fill word's first bit used when nothing is offered
  assert_fill_word_R5: assert property (@(posedge clk) disable iff (rst)
    (word_ready && !word_valid) |=> (tx_bit == ~($past(tx_bit) ^ FILL_LSB)));

  // R6: no tick or no ptt leaves both level registers untouched
  assert_hold_when_paused_R6: assert property (@(posedge clk) disable iff (rst)
    (!(ptt && bit_tick)) |=> ($stable(line_q) && $stable(tx_bit)));

  // R6: idle line and transmitter off while ptt is low
  assert_idle_line_R6: assert property (@(posedge clk) disable iff (rst)
    !ptt |-> (line_bit == IDLE_LEVEL && !tx_en && !word_ready));

  // R7: reset leaves both level registers at 0
  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (line_q == 1'b0 && tx_bit == 1'b0));

endmodule

bind nrzi_tx_serializer nrzi_tx_checker #(
  .FILL_LSB   (FILL_WORD[0]),
  .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_tick   (bit_tick),
  .ptt        (ptt),
  .word_lsb   (word_data[0]),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .line_bit   (line_bit),
  .tx_en      (tx_en),
  .line_q     (line_q),
  .tx_bit     (tx_bit)
);

// File: tb/nrzi_tx_serializer_tb.sv
module nrzi_tx_serializer_tb;

  localparam int           CLK_P = 10;
  localparam int           W     = 4;
  localparam logic [W-1:0] FILL  = 4'h9;
  localparam logic         IDLE  = 1'b1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_tick = 1'b0;
  logic         ptt = 1'b0;
  logic [W-1:0] word_data = '0;
  logic         word_valid = 1'b0;
  logic         word_ready;
  logic         line_bit;
  logic         tx_en;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference state derived from the requirements
  logic         m_tx;    // level to be driven on the next tick
  int           m_pos;   // bit position within the current word
  logic [W-1:0] m_cur;   // word being sent

  always #(CLK_P/2) clk = ~clk;

  nrzi_tx_serializer #(
    .WORD_W     (W),
    .FILL_WORD  (FILL),
    .IDLE_LEVEL (IDLE)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .ptt        (ptt),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .line_bit   (line_bit),
    .tx_en      (tx_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_reset();
    m_tx  = 1'b0;
    m_pos = 0;
    m_cur = '0;
  endtask

  // One enabled tick: the word is offered (if v) for the whole tick
  task automatic send_tick(input logic v, input logic [W-1:0] w);
    logic exp_line;
    logic d;
    @(negedge clk);
    bit_tick   = 1'b1;
    word_valid = v;
    word_data  = w;
    #1;
    check("R4 word_ready on reload tick only", word_ready, (m_pos == 0));
    if (m_pos == 0) m_cur = v ? w : FILL;   // R5 fill substitution
    d        = m_cur[m_pos];                // R3 LSB first
    exp_line = m_tx;                        // R1 previous level driven
    m_tx     = ~(m_tx ^ d);                 // R2 NRZI rule
    m_pos    = (m_pos + 1) % W;
    @(negedge clk);
    bit_tick   = 1'b0;
    check("R1/R2 line level after tick", line_bit, exp_line);
    check("R7 tx_en high while ptt", tx_en, 1'b1);
    @(negedge clk);
    check("R1 line holds between ticks", line_bit, exp_line);
    word_valid = v;
  endtask

  task automatic send_word(input logic v, input logic [W-1:0] w);
    for (int b = 0; b < W; b++) send_tick(v, w);
    word_valid = 1'b0;
  endtask

  // Ticks while ptt is low must be ignored
  task automatic paused_ticks(input int n);
    @(negedge clk);
    ptt = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_tick   = 1'b1;
      word_valid = 1'b1;
      word_data  = 4'h0;
      #1;
      check("R6 no ready while paused", word_ready, 1'b0);
      check("R6 idle line while paused", line_bit, IDLE);
      check("R6 tx_en low while paused", tx_en, 1'b0);
      @(negedge clk);
      bit_tick   = 1'b0;
      word_valid = 1'b0;
    end
    ptt = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R6 reset idle line", line_bit, IDLE);
    check("R6 reset tx_en low", tx_en, 1'b0);
    check("R6 reset no ready", word_ready, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    ptt = 1'b1;
    #1;
    check("R7 cleared line level shown", line_bit, 1'b0);
    check("R4 no ready without tick", word_ready, 1'b0);

    // Corner words
    send_word(1'b1, 4'h0);
    send_word(1'b1, 4'hF);
    send_word(1'b1, 4'h1);
    send_word(1'b1, 4'h8);

    // Exhaustive adjacent pairs of word values
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        send_word(1'b1, 4'(a));
        send_word(1'b1, 4'(b));
      end

    // Fill substitution, including back to back fills
    send_word(1'b0, 4'h3);
    send_word(1'b0, 4'h3);
    send_word(1'b1, 4'h6);
    send_word(1'b0, 4'h0);

    // Pause in the middle of a word, then resume
    send_tick(1'b1, 4'hA);
    send_tick(1'b1, 4'hA);
    paused_ticks(3);
    send_tick(1'b1, 4'hA);
    send_tick(1'b1, 4'hA);
    send_word(1'b1, 4'h5);

    // Reset during a stream
    send_tick(1'b1, 4'hC);
    send_tick(1'b1, 4'hC);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    check("R7 line level cleared by reset", line_bit, 1'b0);
    send_word(1'b1, 4'h7);
    send_word(1'b1, 4'h2);

    finish_run();
  end

endmodule